// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block makes the hardware handshake decisions for one UART channel. On the transmit side it watches the incoming clear-to-send line. When automatic transmit gating is on, it withholds permission to start a new character while the far end holds that line high. It changes that permission only at character boundaries, so a character that has already started always finishes. When the gating is off, the line is ignored and transmission is always permitted.

On the receive side it drives the request-to-send line, which is active low. With automatic mode off, the line follows a software bit. With automatic mode on, the line is forced high when the receive FIFO fill level climbs to the programmed trigger, and a sticky interrupt flag is raised. The line is released once the level falls back below the trigger. The serializer and the FIFOs sit outside the block. They reach it as a fill-level bus and a one-cycle strobe marking the gap between characters.

Top module: `uart_hwflow_ctrl`

## Requirements
- R1: While reset is applied, `rts_n` is 1 (deasserted), `tx_permit` is 1 and `rts_irq` is 0.
- R2: With `auto_cts_en` = 0, `tx_permit` is 1 whatever the level of `cts_n` and whatever the strobes on `char_gap`.
- R3: With `auto_cts_en` = 1, `tx_permit` changes only on a cycle where `char_gap` is 1. On such a strobe it takes the inverse of `cts_n` as seen through SYNC_STAGES (default 2) synchronizer flops: 0 while the line is high and 1 while it is low.
- R4: With `auto_rts_en` = 1, when `rx_level` goes from below `trig_level` to at or above it while `rts_n` is 0, then after the next clock edge `rts_n` is 1 and `rts_irq` is 1.
- R5: The automatic trip of R4 happens only if `rts_n` is already 0 at the crossing. If `sw_rts` = 0 keeps the line high at the crossing, no interrupt is raised. A later `sw_rts` = 1 then drives `rts_n` to 0 even though the level stays above the trigger.
- R6: With `auto_rts_en` = 1 and `sw_rts` = 1, a level below `trig_level` drives `rts_n` to 0 after the next clock edge.
- R7: With `auto_rts_en` = 0, `rts_n` equals the inverse of `sw_rts` one clock edge later, regardless of the fill level.
- R8: `rts_irq` stays 1 until a cycle with `irq_ack` = 1, which clears it at that edge. A new trip in the same cycle as an acknowledge leaves the flag set.
- R9: The trigger comparison is inclusive: a level equal to `trig_level` trips, and a level of `trig_level` - 1 does not.
- R10: Clearing `auto_rts_en` while the line is held high by the automatic trip returns `rts_n` to the inverse of `sw_rts` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_n | input | 1 | Clear-to-send line from the far end, active low, asynchronous |
| char_gap | input | 1 | One-cycle strobe from the transmitter between characters |
| auto_cts_en | input | 1 | Enables gating of transmission by `cts_n` |
| auto_rts_en | input | 1 | Enables automatic control of `rts_n` by the FIFO level |
| sw_rts | input | 1 | Software request bit; 1 drives `rts_n` low |
| rx_level | input | LVL_W | Receive FIFO fill level (0 to FIFO_DEPTH) |
| trig_level | input | LVL_W | Programmed receive trigger level |
| irq_ack | input | 1 | Clears the automatic-RTS interrupt flag |
| rts_n | output | 1 | Request-to-send line, active low |
| tx_permit | output | 1 | 1 when the transmitter may start a new character |
| rts_irq | output | 1 | Sticky flag set by an automatic RTS trip |

## Verification
The hardest state to reach is the one where the fill level crosses the trigger while the line is already high because software holds it there. In that state the crossing must be swallowed, and later re-asserting the software bit must not trip anything. The bench reaches it by dropping `sw_rts` first, then walking the level from below to above the trigger. It then raises `sw_rts` again and watches the line stay low over several cycles. The same-cycle race between a fresh trip and an acknowledge is staged by driving both on one edge.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;

  localparam int unsigned DEF_FIFO_DEPTH  = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;

  function automatic int unsigned level_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/hwflow_rst_sync.sv
module hwflow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] rs_q;
  logic [STAGES-1:0] rs_d;

  generate
    if (STAGES == 1) begin : g_one
      assign rs_d = 1'b1;
    end else begin : g_many
      assign rs_d = {rs_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_core_n = rs_q[STAGES-1];

endmodule

// File: rtl/hwflow_cts_gate.sv
module hwflow_cts_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic char_gap,
  input  logic auto_cts_en,
  output logic tx_permit
);

  logic cts_seen_n;

  // Synchronizer variant picked by the stage count; zero stages bypass it.
  generate
    if (SYNC_STAGES == 0) begin : g_bypass
      assign cts_seen_n = cts_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] stg_q;
      logic [SYNC_STAGES-1:0] stg_d;
      if (SYNC_STAGES == 1) begin : g_one
        assign stg_d = cts_n;
      end else begin : g_many
        assign stg_d = {stg_q[SYNC_STAGES-2:0], cts_n};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
      end
      assign cts_seen_n = stg_q[SYNC_STAGES-1];
    end
  endgenerate

  logic permit_q;
  logic permit_d;
  logic permit_en;

  // The permit is only re-evaluated in the gap between characters.
  always_comb begin
    permit_en = char_gap;
    permit_d  = ~cts_seen_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         permit_q <= 1'b1;
    else if (permit_en) permit_q <= permit_d;
  end

  assign tx_permit = ~auto_cts_en | permit_q;

endmodule

// File: rtl/hwflow_rts_ctrl.sv
module hwflow_rts_ctrl #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  output logic             rts_n,
  output logic             trip
);

  logic above_now;
  logic above_q;
  logic hold_q;
  logic hold_d;
  logic line_q;
  logic line_d;

  always_comb begin
    above_now = (rx_level >= trig_level);
    // A trip is a fresh upward crossing seen while the line is asserted.
    trip      = auto_rts_en & above_now & ~above_q & ~line_q;
    if (!auto_rts_en)  hold_d = 1'b0;
    else if (hold_q)   hold_d = above_now;
    else               hold_d = trip;
    line_d = hold_d | ~sw_rts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      hold_q  <= 1'b0;
      line_q  <= 1'b1;
    end else begin
      above_q <= above_now;
      hold_q  <= hold_d;
      line_q  <= line_d;
    end
  end

  assign rts_n = line_q;

endmodule

// File: rtl/hwflow_irq_flag.sv
module hwflow_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  // A new event wins over an acknowledge in the same cycle.
  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/uart_hwflow_ctrl.sv
module uart_hwflow_ctrl
  import hwflow_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = DEF_FIFO_DEPTH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = DEF_RST_STAGES,
  localparam int unsigned LVL_W      = level_width(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_n,
  input  logic             char_gap,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] trig_level,
  input  logic             irq_ack,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             rts_irq
);

  logic rst_core_n;
  logic rts_trip;

  hwflow_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  hwflow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) i_cts_gate (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .cts_n       (cts_n),
    .char_gap    (char_gap),
    .auto_cts_en (auto_cts_en),
    .tx_permit   (tx_permit)
  );

  hwflow_rts_ctrl #(.LVL_W(LVL_W)) i_rts_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .rx_level    (rx_level),
    .trig_level  (trig_level),
    .auto_rts_en (auto_rts_en),
    .sw_rts      (sw_rts),
    .rts_n       (rts_n),
    .trip        (rts_trip)
  );

  hwflow_irq_flag i_irq_flag (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (rts_trip),
    .ack   (irq_ack),
    .flag  (rts_irq)
  );

endmodule

// File: rtl/hwflow_checker.sv
module hwflow_checker #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             char_gap,
  input logic             auto_cts_en,
  input logic             auto_rts_en,
  input logic             sw_rts,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] trig_level,
  input logic             irq_ack,
  input logic             rts_n,
  input logic             tx_permit,
  input logic             rts_irq
);

  p_cts_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |-> tx_permit);

  p_permit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && !char_gap) |=> (!auto_cts_en || $stable(tx_permit)));

  p_trip_drives_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_irq) |-> rts_n);

  p_trip_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_irq) |-> !$past(rts_n));

  p_release_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && sw_rts && (rx_level < trig_level)) |=> !rts_n);

  p_gpo_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(sw_rts)));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_irq && !irq_ack) |=> rts_irq);

endmodule

bind uart_hwflow_ctrl hwflow_checker #(.LVL_W(LVL_W)) i_hwflow_checker (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .char_gap    (char_gap),
  .auto_cts_en (auto_cts_en),
  .auto_rts_en (auto_rts_en),
  .sw_rts      (sw_rts),
  .rx_level    (rx_level),
  .trig_level  (trig_level),
  .irq_ack     (irq_ack),
  .rts_n       (rts_n),
  .tx_permit   (tx_permit),
  .rts_irq     (rts_irq)
);

// File: tb/test_uart_hwflow_ctrl.sv
module test_uart_hwflow_ctrl;

  localparam int unsigned LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cts_n;
  logic             char_gap;
  logic             auto_cts_en;
  logic             auto_rts_en;
  logic             sw_rts;
  logic [LVL_W-1:0] rx_level;
  logic [LVL_W-1:0] trig_level;
  logic             irq_ack;
  logic             rts_n;
  logic             tx_permit;
  logic             rts_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  uart_hwflow_ctrl i_uart_hwflow_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n       (cts_n),
    .char_gap    (char_gap),
    .auto_cts_en (auto_cts_en),
    .auto_rts_en (auto_rts_en),
    .sw_rts      (sw_rts),
    .rx_level    (rx_level),
    .trig_level  (trig_level),
    .irq_ack     (irq_ack),
    .rts_n       (rts_n),
    .tx_permit   (tx_permit),
    .rts_irq     (rts_irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap_pulse();
    char_gap = 1'b1;
    step(1);
    char_gap = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cts_n = 1'b1; char_gap = 1'b0; auto_cts_en = 1'b0;
    auto_rts_en = 1'b0; sw_rts = 1'b0; rx_level = '0; trig_level = 5'd8;
    irq_ack = 1'b0;
    step(3);
    check("R1", "rts_n in reset", rts_n, 1);
    check("R1", "tx_permit in reset", tx_permit, 1);
    check("R1", "rts_irq in reset", rts_irq, 0);
    rst_n = 1'b1;
    step(5);
  endtask

  task automatic t_cts_ignored();
    auto_cts_en = 1'b0;
    cts_n = 1'b1;
    step(4);
    gap_pulse();
    check("R2", "permit with line high, gating off", tx_permit, 1);
    cts_n = 1'b0;
    step(4);
    gap_pulse();
    check("R2", "permit with line low, gating off", tx_permit, 1);
  endtask

  task automatic t_cts_gating();
    auto_cts_en = 1'b1;
    cts_n = 1'b1;
    step(4);
    check("R3", "permit held without gap strobe", tx_permit, 1);
    gap_pulse();
    check("R3", "permit dropped at gap", tx_permit, 0);
    cts_n = 1'b0;
    step(4);
    check("R3", "permit stays low until gap", tx_permit, 0);
    gap_pulse();
    check("R3", "permit restored at gap", tx_permit, 1);
    auto_cts_en = 1'b0;
  endtask

  task automatic t_rts_gpo();
    auto_rts_en = 1'b0;
    rx_level = 5'd12;
    sw_rts = 1'b1;
    step(1);
    check("R7", "line follows software bit low", rts_n, 0);
    sw_rts = 1'b0;
    step(1);
    check("R7", "line follows software bit high", rts_n, 1);
    check("R7", "no interrupt in manual mode", rts_irq, 0);
  endtask

  task automatic t_rts_auto();
    rx_level = 5'd7;
    sw_rts = 1'b1;
    auto_rts_en = 1'b1;
    step(2);
    check("R9", "level one below trigger keeps line low", rts_n, 0);
    check("R9", "level one below trigger no interrupt", rts_irq, 0);
    rx_level = 5'd8;
    step(1);
    check("R4", "line high after crossing", rts_n, 1);
    check("R4", "interrupt after crossing", rts_irq, 1);
    step(3);
    check("R4", "line stays high above trigger", rts_n, 1);
    rx_level = 5'd7;
    step(1);
    check("R6", "line low after level drops", rts_n, 0);
    check("R8", "flag sticky without acknowledge", rts_irq, 1);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R8", "flag cleared by acknowledge", rts_irq, 0);
  endtask

  task automatic t_rts_gate_high();
    sw_rts = 1'b0;
    rx_level = 5'd4;
    step(2);
    rx_level = 5'd10;
    step(2);
    check("R5", "no interrupt when line already high", rts_irq, 0);
    check("R5", "line high from software", rts_n, 1);
    sw_rts = 1'b1;
    step(1);
    check("R5", "software asserts line above trigger", rts_n, 0);
    step(3);
    check("R5", "line stays low without new crossing", rts_n, 0);
    check("R5", "still no interrupt", rts_irq, 0);
  endtask

  task automatic t_ack_race();
    rx_level = 5'd4;
    step(2);
    rx_level = 5'd10;
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R8", "trip wins over same-cycle acknowledge", rts_irq, 1);
    check("R4", "line high after second trip", rts_n, 1);
  endtask

  task automatic t_disable_while_held();
    auto_rts_en = 1'b0;
    step(1);
    check("R10", "disabling releases hold to software bit", rts_n, 0);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R8", "flag cleared after disable", rts_irq, 0);
  endtask

  initial begin
    t_reset();
    t_cts_ignored();
    t_cts_gating();
    t_rts_gpo();
    t_rts_auto();
    t_rts_gate_high();
    t_ack_race();
    t_disable_while_held();
    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule